// File: doc/BRIEF.md
# Ethernet Transmit Status and Collision Tracker

This block follows a single frame through the transmit side of a half-duplex Ethernet MAC. It records every event that matters to software and assembles them into a 16-bit transmit status word. A frame opens with a one-cycle start pulse. While the frame is open, the block counts collisions and bit-time ticks. It raises a one-cycle abort pulse when the frame has to be given up: too many collisions, a collision outside the allowed window, a deferral that waited too long, a FIFO that drained, a parity fault or an external halt request.

Every frame ends in one of two ways: the transmit logic signals its end, or the block aborts it. Either way a one-cycle done pulse follows and the completion bit is set. The status word then holds its value until the next start pulse, and events that arrive in between are ignored. Backoff timing and the retransmission datapath live elsewhere; the block only says when to stop.

Top module: `txs_tracker`

## Requirements
- R1: After reset, and in the cycle after a start pulse, the status word is 0x0000 and abort and done are low; every per-frame field, including the collision count, clears only on a start pulse.
- R2: Bits 3:0 of the status hold the number of collisions seen on the open frame, one more for each collision that falls inside the collision window.
- R3: On the MAX_COLL-th (16th) counted collision, bits 3:0 read 0, bit 4 (excessive collisions) sets and abort pulses.
- R4: The collision window is LATE_BITS bit ticks (512), counted from the start pulse or from the last counted collision. A collision seen once that many ticks have passed sets bit 12 (late collision), pulses abort and leaves bits 3:0 unchanged.
- R5: Any cycle of deferral-waiting in the open frame sets bit 5. After DEFER_BITS consecutive ticks of waiting (32768), bit 9 sets and abort pulses. A cycle without waiting restarts that run.
- R6: When the frame ends normally and carrier was never high during it, bit 10 (no carrier) sets.
- R7: A FIFO-empty cycle in the open frame sets bit 8 (underrun) and pulses abort; a parity-fault cycle sets bit 13 and pulses abort.
- R8: A halt request in the open frame sets bit 15 and pulses abort.
- R9: An SQE-missing cycle sets bit 11 and a hold cycle sets bit 6; neither aborts.
- R10: The cycle after a frame end or an abort, done pulses for one cycle and bit 14 (complete) sets. Until the next start pulse, no status bit other than bit 7 changes and no abort is raised.
- R11: Bit 15 is also set when any of bits 4, 8, 9, 10, 11, 12 or 13 is set. Bit 7 is set when bit 15 is set, or when bit 14 is set and the completion-interrupt enable input is high.
- R12: A frame end and an abort cause in the same cycle record both: the error bit sets, bit 14 sets, and done pulses exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One pulse per bit time |
| frm_start | input | 1 | Opens a new frame, clears all per-frame state |
| frm_end | input | 1 | Normal end of the open frame |
| coll_det | input | 1 | Collision seen this cycle |
| carrier | input | 1 | Carrier sense |
| fifo_empty | input | 1 | Transmit FIFO ran dry |
| fifo_par_err | input | 1 | Transmit FIFO parity fault |
| defer_wait | input | 1 | MAC is deferring to traffic |
| halt_req | input | 1 | Stop transmission now |
| hold_req | input | 1 | Data transfer held (paused) |
| sqe_miss | input | 1 | SQE test signal did not arrive |
| cmpl_irq_en | input | 1 | Raise interrupt bit on completion |
| tx_status | output | 16 | Assembled status word |
| abort_o | output | 1 | One-cycle pulse: give up the frame |
| done_o | output | 1 | One-cycle pulse: frame finished or discarded |

## Verification
The collision count and the late-collision window are judged on the same input. A collision that lands exactly on tick LATE_BITS-1 must count, and one that lands on tick LATE_BITS must abort without counting. The bench sweeps collisions across that boundary, and also sends a collision after a counted retry to show the window restarts. Frame end and abort also collide: the bench drives a frame end together with a FIFO-empty cycle, then expects one done pulse, one abort pulse, and a word carrying both underrun and completion with no spurious no-carrier bit.

// File: rtl/txs_pkg.sv
package txs_pkg;

  // Status bit positions that software decodes
  localparam int B_EXCESS = 4;
  localparam int B_DEFERRED = 5;
  localparam int B_PAUSED = 6;
  localparam int B_IRQ = 7;
  localparam int B_UNDER = 8;
  localparam int B_DEFER_ERR = 9;
  localparam int B_NO_CARR = 10;
  localparam int B_SQE = 11;
  localparam int B_LATE = 12;
  localparam int B_PARITY = 13;
  localparam int B_COMPLETE = 14;
  localparam int B_HALTED = 15;

  typedef struct packed {
    logic excess;
    logic deferred;
    logic paused;
    logic underrun;
    logic defer_err;
    logic no_carr;
    logic sqe;
    logic late;
    logic parity;
    logic halt;
    logic complete;
  } txs_flags_t;

  // Any flag that counts as an error condition
  function automatic logic any_error(input txs_flags_t f);
    return f.excess | f.underrun | f.defer_err | f.no_carr | f.sqe | f.late | f.parity;
  endfunction

  // Pack flags and collision count into the status word
  function automatic logic [15:0] pack_status(input txs_flags_t f, input logic [3:0] cnt,
                                              input logic irq_en);
    logic [15:0] w;
    logic err;
    err = any_error(f);
    w = '0;
    w[3:0] = cnt;
    w[B_EXCESS] = f.excess;
    w[B_DEFERRED] = f.deferred;
    w[B_PAUSED] = f.paused;
    w[B_UNDER] = f.underrun;
    w[B_DEFER_ERR] = f.defer_err;
    w[B_NO_CARR] = f.no_carr;
    w[B_SQE] = f.sqe;
    w[B_LATE] = f.late;
    w[B_PARITY] = f.parity;
    w[B_COMPLETE] = f.complete;
    w[B_HALTED] = f.halt | err;
    w[B_IRQ] = f.halt | err | (f.complete & irq_en);
    return w;
  endfunction

endpackage

// File: rtl/txs_coll_ctr.sv
module txs_coll_ctr #(
  parameter int MAX_COLL = 16,
  parameter int LATE_BITS = 512,
  localparam int CW = $clog2(MAX_COLL),
  localparam int PW = $clog2(LATE_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          live,
  input  logic          bit_tick,
  input  logic          coll,
  output logic [CW-1:0] count,
  output logic          excess,
  output logic          late,
  output logic          hit_excess,
  output logic          hit_late
);

  logic [PW-1:0] pos;
  logic past_window;
  logic hit_count;

  function automatic logic window_over(input logic [PW-1:0] p);
    return p >= PW'(LATE_BITS);
  endfunction

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c, input logic wrap);
    return wrap ? '0 : c + 1'b1;
  endfunction

  assign past_window = window_over(pos);
  assign hit_late    = live & coll & past_window;
  assign hit_count   = live & coll & ~past_window;
  assign hit_excess  = hit_count & (count == CW'(MAX_COLL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      count  <= '0;
      excess <= 1'b0;
      late   <= 1'b0;
    end else if (clr) begin
      pos    <= '0;
      count  <= '0;
      excess <= 1'b0;
      late   <= 1'b0;
    end else begin
      if (hit_count)
        pos <= '0;
      else if (live && bit_tick && !past_window)
        pos <= pos + 1'b1;
      if (hit_count)
        count <= bump(count, hit_excess);
      if (hit_excess)
        excess <= 1'b1;
      if (hit_late)
        late <= 1'b1;
    end
  end

endmodule

// File: rtl/txs_defer_tmr.sv
module txs_defer_tmr #(
  parameter int DEFER_BITS = 32768,
  localparam int DW = $clog2(DEFER_BITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic live,
  input  logic bit_tick,
  input  logic waiting,
  output logic deferred,
  output logic defer_err,
  output logic hit_expire
);

  logic [DW-1:0] dcnt;

  function automatic logic at_limit(input logic [DW-1:0] c);
    return c == DW'(DEFER_BITS - 1);
  endfunction

  assign hit_expire = live & waiting & bit_tick & at_limit(dcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt      <= '0;
      deferred  <= 1'b0;
      defer_err <= 1'b0;
    end else if (clr) begin
      dcnt      <= '0;
      deferred  <= 1'b0;
      defer_err <= 1'b0;
    end else begin
      if (!waiting)
        dcnt <= '0;
      else if (live && bit_tick && dcnt < DW'(DEFER_BITS))
        dcnt <= dcnt + 1'b1;
      if (live && waiting)
        deferred <= 1'b1;
      if (hit_expire)
        defer_err <= 1'b1;
    end
  end

endmodule

// File: rtl/txs_tracker.sv
module txs_tracker #(
  parameter int MAX_COLL = 16,
  parameter int LATE_BITS = 512,
  parameter int DEFER_BITS = 32768,
  localparam int CW = $clog2(MAX_COLL)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        frm_start,
  input  logic        frm_end,
  input  logic        coll_det,
  input  logic        carrier,
  input  logic        fifo_empty,
  input  logic        fifo_par_err,
  input  logic        defer_wait,
  input  logic        halt_req,
  input  logic        hold_req,
  input  logic        sqe_miss,
  input  logic        cmpl_irq_en,
  output logic [15:0] tx_status,
  output logic        abort_o,
  output logic        done_o
);
  import txs_pkg::*;

  logic          active;
  logic          live;
  logic          carr_seen;
  logic [CW-1:0] coll_cnt;
  logic          excess_f, late_f, hit_excess, hit_late;
  logic          deferred_f, defer_err_f, hit_expire;
  logic          abort_evt, end_evt;
  txs_flags_t    flags;
  logic          underrun_f, parity_f, halt_f, sqe_f, paused_f, no_carr_f, complete_f;

  // Events count only while a frame is open and not being restarted
  assign live = active & ~frm_start;

  txs_coll_ctr #(.MAX_COLL(MAX_COLL), .LATE_BITS(LATE_BITS)) u_coll (
    .clk(clk), .rst_n(rst_n), .clr(frm_start), .live(live), .bit_tick(bit_tick),
    .coll(coll_det), .count(coll_cnt), .excess(excess_f), .late(late_f),
    .hit_excess(hit_excess), .hit_late(hit_late)
  );

  txs_defer_tmr #(.DEFER_BITS(DEFER_BITS)) u_defer (
    .clk(clk), .rst_n(rst_n), .clr(frm_start), .live(live), .bit_tick(bit_tick),
    .waiting(defer_wait), .deferred(deferred_f), .defer_err(defer_err_f),
    .hit_expire(hit_expire)
  );

  assign abort_evt = live & (hit_excess | hit_late | hit_expire | fifo_empty |
                             fifo_par_err | halt_req);
  assign end_evt   = live & (frm_end | abort_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      carr_seen  <= 1'b0;
      underrun_f <= 1'b0;
      parity_f   <= 1'b0;
      halt_f     <= 1'b0;
      sqe_f      <= 1'b0;
      paused_f   <= 1'b0;
      no_carr_f  <= 1'b0;
      complete_f <= 1'b0;
      abort_o    <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      abort_o <= abort_evt;
      done_o  <= end_evt;
      if (frm_start) begin
        active     <= 1'b1;
        carr_seen  <= 1'b0;
        underrun_f <= 1'b0;
        parity_f   <= 1'b0;
        halt_f     <= 1'b0;
        sqe_f      <= 1'b0;
        paused_f   <= 1'b0;
        no_carr_f  <= 1'b0;
        complete_f <= 1'b0;
      end else if (live) begin
        if (carrier)      carr_seen  <= 1'b1;
        if (fifo_empty)   underrun_f <= 1'b1;
        if (fifo_par_err) parity_f   <= 1'b1;
        if (halt_req)     halt_f     <= 1'b1;
        if (sqe_miss)     sqe_f      <= 1'b1;
        if (hold_req)     paused_f   <= 1'b1;
        if (frm_end && !abort_evt && !carr_seen && !carrier)
          no_carr_f <= 1'b1;
        if (end_evt) begin
          complete_f <= 1'b1;
          active     <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    flags.excess    = excess_f;
    flags.deferred  = deferred_f;
    flags.paused    = paused_f;
    flags.underrun  = underrun_f;
    flags.defer_err = defer_err_f;
    flags.no_carr   = no_carr_f;
    flags.sqe       = sqe_f;
    flags.late      = late_f;
    flags.parity    = parity_f;
    flags.halt      = halt_f;
    flags.complete  = complete_f;
  end

  assign tx_status = pack_status(flags, 4'(coll_cnt), cmpl_irq_en);

endmodule

module txs_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frm_start,
  input logic        coll_det,
  input logic        live,
  input logic [15:0] tx_status,
  input logic        abort_o,
  input logic        done_o
);

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> (tx_status == 16'h0000)); // R1

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!coll_det && !frm_start) |=> $stable(tx_status[3:0])); // R2

  AST_EXCESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_status[4] |-> (tx_status[3:0] == 4'd0)); // R3

  AST_LATE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_status[12]) |-> abort_o); // R4

  AST_DEFER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_status[9]) |-> abort_o); // R5

  AST_ABORT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (done_o && tx_status[14])); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && !frm_start) |=> $stable({tx_status[15:8], tx_status[6:0]})); // R10

  AST_ERR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tx_status[13:8]) || tx_status[4]) |-> (tx_status[15] && tx_status[7])); // R11

endmodule

bind txs_tracker txs_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .coll_det(coll_det), .live(live),
  .tx_status(tx_status), .abort_o(abort_o), .done_o(done_o)
);

// File: tb/sim_txs_tracker.sv
module sim_txs_tracker;

  localparam int MAXC  = 16;
  localparam int LATE  = 16;
  localparam int DEFER = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, frm_start = 1'b0, frm_end = 1'b0, coll_det = 1'b0;
  logic carrier = 1'b0, fifo_empty = 1'b0, fifo_par_err = 1'b0, defer_wait = 1'b0;
  logic halt_req = 1'b0, hold_req = 1'b0, sqe_miss = 1'b0, cmpl_irq_en = 1'b0;
  logic [15:0] tx_status;
  logic abort_o, done_o;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  txs_tracker #(.MAX_COLL(MAXC), .LATE_BITS(LATE), .DEFER_BITS(DEFER)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frm_start(frm_start),
    .frm_end(frm_end), .coll_det(coll_det), .carrier(carrier), .fifo_empty(fifo_empty),
    .fifo_par_err(fifo_par_err), .defer_wait(defer_wait), .halt_req(halt_req),
    .hold_req(hold_req), .sqe_miss(sqe_miss), .cmpl_irq_en(cmpl_irq_en),
    .tx_status(tx_status), .abort_o(abort_o), .done_o(done_o)
  );

  // Expected word, built by summing bit weights
  function automatic logic [15:0] ew(int cnt, bit ex, bit dfd, bit pau, bit und, bit derr,
                                     bit nc, bit sqe, bit late, bit par, bit hlt, bit comp,
                                     bit ien);
    int v;
    bit bad;
    bad = ex || und || derr || nc || sqe || late || par;
    v = cnt % 16;
    v += ex * 16 + dfd * 32 + pau * 64;
    v += (bad || hlt || (comp && ien)) ? 128 : 0;
    v += und * 256 + derr * 512 + nc * 1024 + sqe * 2048;
    v += late * 4096 + par * 8192 + comp * 16384;
    v += (bad || hlt) ? 32768 : 0;
    return v[15:0];
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic start_frame();
    frm_start = 1'b1;
    @(negedge clk);
    frm_start = 1'b0;
  endtask

  task automatic end_frame();
    frm_end = 1'b1;
    @(negedge clk);
    frm_end = 1'b0;
  endtask

  task automatic ticks(input int n);
    bit_tick = 1'b1;
    repeat (n) @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic coll_pulse();
    coll_det = 1'b1;
    @(negedge clk);
    coll_det = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset word", tx_status, 16'h0000);
    chk("R1 reset abort", 16'(abort_o), 16'h0);
    chk("R1 reset done", 16'(done_o), 16'h0);

    // R2 / R3 collision sweep 0..16
    for (int n = 0; n <= MAXC; n++) begin
      start_frame();
      chk("R1 start clear", tx_status, 16'h0000);
      carrier = 1'b1;
      for (int i = 0; i < n; i++) begin
        coll_pulse();
        if (i == MAXC - 1) chk("R3 abort on last", 16'(abort_o), 16'h1);
        else chk("R2 no abort", 16'(abort_o), 16'h0);
        ticks(2);
      end
      if (n < MAXC) begin
        chk("R2 count", tx_status, ew(n, 0,0,0,0,0,0,0,0,0,0,0,0));
        end_frame();
        chk("R10 done", 16'(done_o), 16'h1);
        chk("R2 final", tx_status, ew(n, 0,0,0,0,0,0,0,0,0,0,1,0));
      end else begin
        chk("R3 word", tx_status, ew(0, 1,0,0,0,0,0,0,0,0,0,1,0));
      end
      carrier = 1'b0;
    end

    // R4 late-collision boundary sweep
    for (int k = LATE - 2; k <= LATE + 1; k++) begin
      start_frame();
      carrier = 1'b1;
      ticks(k);
      coll_pulse();
      if (k >= LATE) begin
        chk("R4 late abort", 16'(abort_o), 16'h1);
        chk("R4 late word", tx_status, ew(0, 0,0,0,0,0,0,0,1,0,0,1,0));
      end else begin
        chk("R4 in window", 16'(abort_o), 16'h0);
        chk("R4 counted", tx_status, ew(1, 0,0,0,0,0,0,0,0,0,0,0,0));
        end_frame();
      end
      carrier = 1'b0;
    end

    // R4 window restarts after a counted collision
    start_frame();
    carrier = 1'b1;
    ticks(LATE - 1);
    coll_pulse();
    ticks(LATE - 1);
    coll_pulse();
    chk("R4 retry window", tx_status, ew(2, 0,0,0,0,0,0,0,0,0,0,0,0));
    ticks(LATE);
    coll_pulse();
    chk("R4 retry late", tx_status, ew(2, 0,0,0,0,0,0,0,1,0,0,1,0));
    carrier = 1'b0;

    // R5 deferral
    start_frame();
    defer_wait = 1'b1;
    ticks(DEFER - 1);
    chk("R5 below limit abort", 16'(abort_o), 16'h0);
    chk("R5 deferred", tx_status, ew(0, 0,1,0,0,0,0,0,0,0,0,0,0));
    defer_wait = 1'b0;
    @(negedge clk);
    defer_wait = 1'b1;
    ticks(DEFER);
    defer_wait = 1'b0;
    chk("R5 limit abort", 16'(abort_o), 16'h1);
    chk("R5 limit word", tx_status, ew(0, 0,1,0,0,1,0,0,0,0,0,1,0));

    // R6 no carrier vs carrier
    start_frame();
    ticks(3);
    end_frame();
    chk("R6 no carrier", tx_status, ew(0, 0,0,0,0,0,1,0,0,0,0,1,0));
    chk("R11 irq on error", 16'(tx_status[7]), 16'h1);

    // R7 underrun, parity
    start_frame();
    carrier = 1'b1;
    fifo_empty = 1'b1;
    @(negedge clk);
    fifo_empty = 1'b0;
    chk("R7 underrun abort", 16'(abort_o), 16'h1);
    chk("R7 underrun word", tx_status, ew(0, 0,0,0,1,0,0,0,0,0,0,1,0));
    start_frame();
    fifo_par_err = 1'b1;
    @(negedge clk);
    fifo_par_err = 1'b0;
    chk("R7 parity abort", 16'(abort_o), 16'h1);
    chk("R7 parity word", tx_status, ew(0, 0,0,0,0,0,0,0,0,1,0,1,0));

    // R8 halt
    start_frame();
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    chk("R8 halt abort", 16'(abort_o), 16'h1);
    chk("R8 halt word", tx_status, ew(0, 0,0,0,0,0,0,0,0,0,1,1,0));

    // R9 SQE and pause do not abort
    start_frame();
    sqe_miss = 1'b1;
    @(negedge clk);
    sqe_miss = 1'b0;
    chk("R9 sqe no abort", 16'(abort_o), 16'h0);
    hold_req = 1'b1;
    @(negedge clk);
    hold_req = 1'b0;
    chk("R9 hold no abort", 16'(abort_o), 16'h0);
    end_frame();
    chk("R9 word", tx_status, ew(0, 0,0,1,0,0,0,1,0,0,0,1,0));
    start_frame();
    hold_req = 1'b1;
    @(negedge clk);
    hold_req = 1'b0;
    end_frame();
    chk("R9 pause only", tx_status, ew(0, 0,0,1,0,0,0,0,0,0,0,1,0));
    carrier = 1'b0;

    // R11 completion interrupt enable
    start_frame();
    carrier = 1'b1;
    cmpl_irq_en = 1'b1;
    end_frame();
    chk("R11 irq enabled", tx_status, ew(0, 0,0,0,0,0,0,0,0,0,0,1,1));
    cmpl_irq_en = 1'b0;
    #1;
    chk("R11 irq disabled", tx_status, ew(0, 0,0,0,0,0,0,0,0,0,0,1,0));

    // R12 end and abort together, then R10 ignore after end
    start_frame();
    ticks(2);
    frm_end = 1'b1;
    fifo_empty = 1'b1;
    @(negedge clk);
    frm_end = 1'b0;
    fifo_empty = 1'b0;
    chk("R12 abort", 16'(abort_o), 16'h1);
    chk("R12 done", 16'(done_o), 16'h1);
    chk("R12 word", tx_status, ew(0, 0,0,0,1,0,0,0,0,0,0,1,0));
    coll_pulse();
    chk("R12 single done", 16'(done_o), 16'h0);
    fifo_par_err = 1'b1;
    halt_req = 1'b1;
    @(negedge clk);
    fifo_par_err = 1'b0;
    halt_req = 1'b0;
    chk("R10 ignored abort", 16'(abort_o), 16'h0);
    chk("R10 ignored word", tx_status, ew(0, 0,0,0,1,0,0,0,0,0,0,1,0));
    carrier = 1'b0;
    start_frame();
    chk("R1 restart clear", tx_status, 16'h0000);
    end_frame();

    finish_run();
  end

endmodule